// File: doc/BRIEF.md
# Instruction exception type classifier

This block lives in the decode stage of a small 32-bit RISC pipeline and decides, for the instruction being decoded, which instruction-caused exception it raises: a software trap, an illegal-slot fault, a general illegal-instruction fault, or nothing. The decoder hands it an abstract instruction-class code, a valid strobe, an "opcode is undefined" flag and the immediate vector field of a trap instruction. Full opcode decoding, stack pushes and the vector-table fetch all happen elsewhere. The decoder is expected to flag at least every opcode in the 0xF000 to 0xFFFF range as undefined. It may also flag other undefined encodings, but it does not have to.

The key behaviour is context. An undefined opcode that comes right after an instruction which redirects the program counter is an illegal-slot fault. That covers both the delay slot of a delayed branch and the instruction after a non-delayed PC change. Everywhere else, an undefined opcode is a general illegal fault. The block keeps one registered bit recording whether the last valid decode was a PC-changing instruction. The result is presented combinationally, in the same cycle as the valid strobe, as a one-hot type vector plus a vector number.

Top module: `exc_classifier`

## Requirements
- R1: After reset, the context bit is clear. An undefined opcode as the first valid decode, or as the first decode after a reset that interrupted a branch, gives a general illegal fault.
- R2: While `dec_valid` is 0, `exc_type` is 0 and `exc_vec` is 0.
- R3: A valid, defined instruction of class 3 (trap) gives `exc_type` = 3'b001 and `exc_vec` = `trap_imm` in the same cycle.
- R4: A valid undefined opcode whose previous valid decode was a defined class 1 instruction (delayed branch) gives `exc_type` = 3'b010 and `exc_vec` = `SLOT_VEC`.
- R5: A valid undefined opcode whose previous valid decode was a defined instruction of class 2 (non-delayed branch), class 3 (trap) or class 4 (status-register write) also gives `exc_type` = 3'b010 and `exc_vec` = `SLOT_VEC`.
- R6: A valid undefined opcode whose previous valid decode was a defined instruction of class 0, 5, 6 or 7 gives `exc_type` = 3'b100 and `exc_vec` = `GEN_VEC`.
- R7: Cycles with `dec_valid` = 0 leave the context bit unchanged, so the fault type depends only on the most recent valid decode.
- R8: An illegal fault (slot or general) clears the context bit. An undefined opcode right after another one is therefore a general fault.
- R9: When `dec_undef` is 1, the class code is ignored. No trap is reported, and the instruction does not count as PC-changing for the next decode.
- R10: At most one bit of `exc_type` is set. A valid, defined instruction of a class other than 3 gives `exc_type` = 0 and `exc_vec` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Instruction in decode is valid this cycle |
| dec_class | input | 3 | Class code: 0 plain, 1 delayed branch, 2 non-delayed branch, 3 trap, 4 status-register write, 5 to 7 plain |
| dec_undef | input | 1 | Opcode is undefined |
| trap_imm | input | VEC_W | Vector number field of a trap instruction |
| exc_type | output | 3 | One-hot type: bit 0 trap, bit 1 illegal slot, bit 2 general illegal; 0 means none |
| exc_vec | output | VEC_W | Vector number of the reported exception, 0 when none |

## Verification
The hardest situation to reach from the ports is a context that has to survive gaps. Examples are a branch followed by several idle cycles and then an undefined opcode, a slot fault followed straight away by a second undefined opcode, and a reset arriving between a branch and its slot. Directed sequences build each of these on purpose. After that, a long random run mixes valid gaps, undefined flags and every class code, so that chains of back-to-back PC-changing and undefined instructions arise in all combinations. A bench-side model of the context bit predicts every result.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int CLS_W  = 3;
    localparam int TYPE_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_PLAIN   = 3'd0,
        CLS_DBRANCH = 3'd1,
        CLS_BRANCH  = 3'd2,
        CLS_TRAP    = 3'd3,
        CLS_SRWR    = 3'd4
    } cls_e;

    // bit positions inside the one-hot type vector
    localparam int T_TRAP = 0;
    localparam int T_SLOT = 1;
    localparam int T_GEN  = 2;

    typedef struct packed {
        logic pc_chg;
    } ctx_t;

    function automatic logic is_pc_changer(input logic [CLS_W-1:0] c);
        return (c == CLS_DBRANCH) || (c == CLS_BRANCH) ||
               (c == CLS_TRAP)    || (c == CLS_SRWR);
    endfunction
endpackage

// File: rtl/exc_ctx_track.sv
module exc_ctx_track
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [CLS_W-1:0] dec_class,
    input  logic             dec_undef,
    output logic             prev_chg
);
    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (dec_valid) begin
            // an illegal fault enters a handler: context restarts clear
            if (dec_undef) ctx_d.pc_chg = 1'b0;
            else           ctx_d.pc_chg = is_pc_changer(dec_class);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign prev_chg = ctx_q.pc_chg;
endmodule

// File: rtl/exc_type_decode.sv
module exc_type_decode
    import exc_pkg::*;
(
    input  logic              dec_valid,
    input  logic [CLS_W-1:0]  dec_class,
    input  logic              dec_undef,
    input  logic              prev_chg,
    output logic [TYPE_W-1:0] type_oh
);
    always_comb begin
        type_oh = '0;
        if (dec_valid) begin
            if (dec_undef) begin
                if (prev_chg) type_oh[T_SLOT] = 1'b1;
                else          type_oh[T_GEN]  = 1'b1;
            end else if (dec_class == CLS_TRAP) begin
                type_oh[T_TRAP] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_vec_select.sv
module exc_vec_select
    import exc_pkg::*;
#(
    parameter int              VEC_W    = 8,
    parameter logic [VEC_W-1:0] SLOT_VEC = 8'd6,
    parameter logic [VEC_W-1:0] GEN_VEC  = 8'd4
)(
    input  logic [TYPE_W-1:0] type_oh,
    input  logic [VEC_W-1:0]  trap_imm,
    output logic [VEC_W-1:0]  vec
);
    always_comb begin
        vec = '0;
        if (type_oh[T_TRAP]) vec = trap_imm;
        if (type_oh[T_SLOT]) vec = SLOT_VEC;
        if (type_oh[T_GEN])  vec = GEN_VEC;
    end
endmodule

// File: rtl/exc_classifier.sv
module exc_classifier
    import exc_pkg::*;
#(
    parameter int              VEC_W    = 8,
    parameter logic [VEC_W-1:0] SLOT_VEC = 8'd6,
    parameter logic [VEC_W-1:0] GEN_VEC  = 8'd4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [CLS_W-1:0]  dec_class,
    input  logic              dec_undef,
    input  logic [VEC_W-1:0]  trap_imm,
    output logic [TYPE_W-1:0] exc_type,
    output logic [VEC_W-1:0]  exc_vec
);
    logic prev_chg;

    exc_ctx_track i_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_valid (dec_valid),
        .dec_class (dec_class),
        .dec_undef (dec_undef),
        .prev_chg  (prev_chg)
    );

    exc_type_decode i_dec (
        .dec_valid (dec_valid),
        .dec_class (dec_class),
        .dec_undef (dec_undef),
        .prev_chg  (prev_chg),
        .type_oh   (exc_type)
    );

    exc_vec_select #(
        .VEC_W    (VEC_W),
        .SLOT_VEC (SLOT_VEC),
        .GEN_VEC  (GEN_VEC)
    ) i_vec (
        .type_oh  (exc_type),
        .trap_imm (trap_imm),
        .vec      (exc_vec)
    );
endmodule

// File: rtl/exc_classifier_chk.sv
module exc_classifier_chk
    import exc_pkg::*;
#(
    parameter int              VEC_W    = 8,
    parameter logic [VEC_W-1:0] SLOT_VEC = 8'd6,
    parameter logic [VEC_W-1:0] GEN_VEC  = 8'd4
)(
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic [CLS_W-1:0]  dec_class,
    input logic              dec_undef,
    input logic [VEC_W-1:0]  trap_imm,
    input logic [TYPE_W-1:0] exc_type,
    input logic [VEC_W-1:0]  exc_vec
);
    // R2: nothing reported without a valid decode
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (exc_type == '0 && exc_vec == '0));

    // R10: type vector never has two bits set
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exc_type));

    // R3: trap reports its own vector field
    p_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_undef && dec_class == CLS_TRAP) |->
        (exc_type == 3'b001 && exc_vec == trap_imm));

    // R4 / R5: undefined directly after a PC changer is a slot fault
    p_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_undef && $past(dec_valid && !dec_undef &&
         is_pc_changer(dec_class))) |->
        (exc_type == 3'b010 && exc_vec == SLOT_VEC));

    // R8: two undefined opcodes back to back, the second is general
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_undef && $past(dec_valid && dec_undef)) |->
        (exc_type == 3'b100 && exc_vec == GEN_VEC));

    // R9: an undefined opcode is never a trap
    p_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_undef) |-> !exc_type[T_TRAP]);
endmodule

bind exc_classifier exc_classifier_chk #(
    .VEC_W    (VEC_W),
    .SLOT_VEC (SLOT_VEC),
    .GEN_VEC  (GEN_VEC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .dec_class (dec_class),
    .dec_undef (dec_undef),
    .trap_imm  (trap_imm),
    .exc_type  (exc_type),
    .exc_vec   (exc_vec)
);

// File: tb/test_exc_classifier.sv
module test_exc_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_W = 8;
    localparam logic [VEC_W-1:0] SLOT_V = 8'd6;
    localparam logic [VEC_W-1:0] GEN_V  = 8'd4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             dec_valid;
    logic [2:0]       dec_class;
    logic             dec_undef;
    logic [VEC_W-1:0] trap_imm;
    logic [2:0]       exc_type;
    logic [VEC_W-1:0] exc_vec;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    bit  mflag = 0;   // bench model of the context bit

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_classifier #(.VEC_W(VEC_W), .SLOT_VEC(SLOT_V), .GEN_VEC(GEN_V)) i_exc_classifier (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
        .dec_undef(dec_undef), .trap_imm(trap_imm), .exc_type(exc_type), .exc_vec(exc_vec)
    );

    function automatic logic changer(input logic [2:0] c);
        return c == 3'd1 || c == 3'd2 || c == 3'd3 || c == 3'd4;
    endfunction

    function automatic logic [2:0] exp_type(input logic v, input logic [2:0] c,
                                            input logic u, input logic f);
        if (!v) return 3'b000;
        if (u)  return f ? 3'b010 : 3'b100;
        if (c == 3'd3) return 3'b001;
        return 3'b000;
    endfunction

    function automatic logic [VEC_W-1:0] exp_vec(input logic [2:0] t, input logic [VEC_W-1:0] imm);
        case (t)
            3'b001:  return imm;
            3'b010:  return SLOT_V;
            3'b100:  return GEN_V;
            default: return '0;
        endcase
    endfunction

    // drive at negedge, check 1 time unit later, model updates at the next posedge
    task automatic step(input logic v, input logic [2:0] c, input logic u,
                        input logic [VEC_W-1:0] imm, input string tag);
        logic [2:0] et;
        logic [VEC_W-1:0] ev;
        @(negedge clk);
        dec_valid = v; dec_class = c; dec_undef = u; trap_imm = imm;
        #1;
        et = exp_type(v, c, u, mflag);
        ev = exp_vec(et, imm);
        total++;
        if (exc_type !== et || exc_vec !== ev) begin
            bad++;
            $display("FAIL %s: type=%b vec=%0d expected type=%b vec=%0d",
                     tag, exc_type, exc_vec, et, ev);
        end
        if (v) mflag = u ? 1'b0 : changer(c);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dec_valid = 1'b0; dec_class = '0; dec_undef = 1'b0; trap_imm = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mflag = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: done=0 expected done=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R2 / R1: idle after reset, then first undefined is general
        step(0, 3'd3, 1, 8'hFF, "R2 idle after reset");
        step(1, 3'd0, 1, 8'h00, "R1 first undef general");
        // R3: trap vector
        step(1, 3'd3, 0, 8'hA5, "R3 trap vector");
        // R5: undef after trap
        step(1, 3'd0, 1, 8'h00, "R5 undef after trap");
        // R4: delay slot
        step(1, 3'd1, 0, 8'h00, "R10 delayed branch no exc");
        step(1, 3'd0, 1, 8'h00, "R4 undef in delay slot");
        // R5: non-delayed branch and SR write
        step(1, 3'd2, 0, 8'h00, "R10 branch no exc");
        step(1, 3'd0, 1, 8'h00, "R5 undef after branch");
        step(1, 3'd4, 0, 8'h00, "R10 sr write no exc");
        step(1, 3'd6, 1, 8'h00, "R5 undef after sr write");
        // R6: after plain classes
        step(1, 3'd0, 0, 8'h00, "R10 plain no exc");
        step(1, 3'd0, 1, 8'h00, "R6 undef after plain");
        step(1, 3'd7, 0, 8'h00, "R10 class7 no exc");
        step(1, 3'd1, 1, 8'h00, "R6 undef after class7");
        // R7: idle gap keeps context
        step(1, 3'd1, 0, 8'h00, "R10 delayed branch");
        for (int i = 0; i < 3; i++) step(0, 3'd0, 1, 8'h11, "R2 R7 idle gap");
        step(1, 3'd0, 1, 8'h00, "R7 slot after gap");
        // R8: slot fault then undef again
        step(1, 3'd1, 0, 8'h00, "R10 delayed branch");
        step(1, 3'd0, 1, 8'h00, "R4 slot");
        step(1, 3'd0, 1, 8'h00, "R8 second undef general");
        // R9: undef with trap class is not a trap and sets no context
        step(1, 3'd3, 1, 8'h77, "R9 undef trap class");
        step(1, 3'd0, 1, 8'h00, "R9 no context from undef");
        // R1: reset between branch and slot
        step(1, 3'd2, 0, 8'h00, "R10 branch");
        do_reset();
        step(1, 3'd0, 1, 8'h00, "R1 reset clears context");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic v, u;
            logic [2:0] c;
            v = ($urandom % 4) != 0;
            u = ($urandom % 3) == 0;
            c = 3'($urandom % 8);
            step(v, c, u, 8'($urandom), "R10 random");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule